// File: doc/BRIEF.md
# Object collision latch bank

This block watches six display objects on every pixel: two players, two missiles, the ball and the playfield. Each object supplies a one-bit "drawing here" signal. When two objects are both drawing on a visible pixel, the flag for that pair is set. The flag then stays set until software clears it. There are fifteen pairs, so the block holds fifteen sticky flags.

Software reads the flags through a small register port. Eight read addresses each return two flags, in data bits 7 and 6. A write strobe aimed at a single clear address empties every flag at once. The block does not generate objects or resolve display priority. It only observes overlaps.

Top module: `collision_latch_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every flag is clear and `rd_data` is 0x00.
- R2: A pair's flag sets at the clock edge where `pix_valid` is high and both of that pair's object inputs are high.
- R3: A set flag stays set, whatever the object inputs do, until a clear occurs.
- R4: When `pix_valid` is low, no flag sets, even if objects overlap.
- R5: A cycle with `wr_en` high and `wr_addr` equal to `CLEAR_ADDR` (default 0x2C) clears all fifteen flags. A write to any other address leaves every flag unchanged.
- R6: If a clear and an overlap occur in the same cycle, the clear wins. No flag is set after that edge.
- R7: The read map places the named flag in bit 7 and then bit 6 of each address:
  - 0: missile0-player1, then missile0-player0
  - 1: missile1-player0, then missile1-player1
  - 2: player0-playfield, then player0-ball
  - 3: player1-playfield, then player1-ball
  - 4: missile0-playfield, then missile0-ball
  - 5: missile1-playfield, then missile1-ball
  - 6: ball-playfield in bit 7 only
  - 7: player0-player1, then missile0-missile1
- R8: Bits 5..0 of `rd_data` always read 0. Bit 6 at address 6 always reads 0.
- R9: `rd_data` is registered. It shows the flags as they stood before edge N, for the `rd_addr` presented before edge N, and is valid after edge N. Reading never alters any flag.
- R10: An overlap sets only the flags of the pairs whose two objects are both active. All other flags keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | High on visible pixels |
| p0_on | input | 1 | Player 0 drawing this pixel |
| p1_on | input | 1 | Player 1 drawing this pixel |
| m0_on | input | 1 | Missile 0 drawing this pixel |
| m1_on | input | 1 | Missile 1 drawing this pixel |
| bl_on | input | 1 | Ball drawing this pixel |
| pf_on | input | 1 | Playfield drawing this pixel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| rd_addr | input | 3 | Collision read address |
| rd_data | output | 8 | Registered read data |

## Verification
An overlap presented before edge N sets its flag at edge N. A read registered at edge N+1 is the first one that shows it. A clear at edge N makes reads registered at edge N+1 and later return zero. The bench keeps a behavioural pair matrix. At every rising edge it forms the expected read data from the address and the matrix as they stood before that edge, and only then updates the matrix. It compares `rd_data` at the following falling edge, so every sample lands exactly one register after its stimulus. Sweeps cover each pair alone, blanking overlaps, clears at the right and wrong address, and clear-versus-overlap collisions.

// File: rtl/collision_latch_bank.sv
module collision_latch_bank #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              p0_on,
  input  logic              p1_on,
  input  logic              m0_on,
  input  logic              m1_on,
  input  logic              bl_on,
  input  logic              pf_on,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NFLAG = 16;

  logic [NFLAG-1:0] hit;
  logic [NFLAG-1:0] lat;
  logic             clr;

  assign clr = wr_en && (wr_addr == CLEAR_ADDR);

  // slot 2k+1 -> bit 7 of address k, slot 2k -> bit 6
  assign hit[1]  = m0_on & p1_on;
  assign hit[0]  = m0_on & p0_on;
  assign hit[3]  = m1_on & p0_on;
  assign hit[2]  = m1_on & p1_on;
  assign hit[5]  = p0_on & pf_on;
  assign hit[4]  = p0_on & bl_on;
  assign hit[7]  = p1_on & pf_on;
  assign hit[6]  = p1_on & bl_on;
  assign hit[9]  = m0_on & pf_on;
  assign hit[8]  = m0_on & bl_on;
  assign hit[11] = m1_on & pf_on;
  assign hit[10] = m1_on & bl_on;
  assign hit[13] = bl_on & pf_on;
  assign hit[12] = 1'b0;
  assign hit[15] = p0_on & p1_on;
  assign hit[14] = m0_on & m1_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat <= '0;
    else if (clr)       lat <= '0;
    else if (pix_valid) lat <= lat | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= {lat[{rd_addr, 1'b1}], lat[{rd_addr, 1'b0}], 6'b0};
  end
endmodule

// File: rtl/collision_latch_bank_chk.sv
module collision_latch_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_valid,
  input logic        clr,
  input logic [15:0] lat,
  input logic [2:0]  rd_addr,
  input logic [7:0]  rd_data
);
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:0] == 6'd0);

  a_r8_addr6_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 3'd6 |=> rd_data[6] == 1'b0);

  a_r4_blank_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (lat & ~$past(lat)) == 16'd0);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (lat & $past(lat)) == $past(lat));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> lat == 16'd0);

  a_r9_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pix_valid) |=> $stable(lat));
endmodule

bind collision_latch_bank collision_latch_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .clr(clr),
  .lat(lat), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/collision_latch_bank_test.sv
module collision_latch_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [5:0] act = 6'd0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = 6'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  // object index: 0 P0, 1 P1, 2 M0, 3 M1, 4 BL, 5 PF
  bit m [6][6];
  logic [7:0] exp_rd = 8'd0;

  always #2.5 clk = ~clk;

  collision_latch_bank uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .p0_on(act[0]), .p1_on(act[1]), .m0_on(act[2]), .m1_on(act[3]),
    .bl_on(act[4]), .pf_on(act[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] expect_read(input logic [2:0] a);
    case (a)
      3'd0: return {m[2][1], m[2][0], 6'd0};
      3'd1: return {m[3][0], m[3][1], 6'd0};
      3'd2: return {m[0][5], m[0][4], 6'd0};
      3'd3: return {m[1][5], m[1][4], 6'd0};
      3'd4: return {m[2][5], m[2][4], 6'd0};
      3'd5: return {m[3][5], m[3][4], 6'd0};
      3'd6: return {m[4][5], 1'b0, 6'd0};
      default: return {m[0][1], m[2][3], 6'd0};
    endcase
  endfunction

  task automatic wipe();
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) m[i][j] = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wipe();
      exp_rd = 8'd0;
    end else begin
      exp_rd = expect_read(rd_addr);
      if (wr_en && wr_addr == 6'h2C) wipe();
      else if (pix_valid)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            if (i != j && act[i] && act[j]) m[i][j] = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== exp_rd) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, rd_addr, rd_data, exp_rd);
      end
      checks++;
      if (rd_data[5:0] !== 6'd0) begin
        fails++;
        $display("FAIL R8 low bits actual=%02h expected=00", rd_data[5:0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      tick(1);
    end
    tick(1);
  endtask

  task automatic clear_at(input logic [5:0] ad);
    wr_en = 1'b1; wr_addr = ad; tick(1);
    wr_en = 1'b0; wr_addr = 6'd0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    tag = "R1";
    tick(3);
    sweep();
    rst_n = 1'b1;
    sweep();

    tag = "R4";
    pix_valid = 1'b0; act = 6'h3F; tick(4);
    act = 6'd0; sweep();

    tag = "R2/R7/R10";
    for (int i = 0; i < 6; i++)
      for (int j = i + 1; j < 6; j++) begin
        act = 6'd0; act[i] = 1'b1; act[j] = 1'b1;
        pix_valid = 1'b1; tick(1);
        pix_valid = 1'b0; act = 6'd0;
        tag = "R3/R7/R9";
        sweep(); sweep();
        tag = "R5 wrong address";
        clear_at(6'h2B); sweep();
        tag = "R5";
        clear_at(6'h2C); sweep();
        tag = "R2/R7/R10";
      end

    tag = "R6";
    pix_valid = 1'b1; act = 6'h3F;
    wr_en = 1'b1; wr_addr = 6'h2C; tick(1);
    wr_en = 1'b0; pix_valid = 1'b0; act = 6'd0;
    sweep();

    tag = "R3";
    pix_valid = 1'b1; act = 6'b010001; tick(1);
    act = 6'b100010; tick(1);
    act = 6'd0; tick(3); sweep();
    clear_at(6'h2C);

    tag = "R2/R10 random";
    for (int k = 0; k < 600; k++) begin
      act = 6'($urandom);
      pix_valid = 1'($urandom);
      rd_addr = 3'($urandom);
      wr_en = ($urandom % 16) == 0;
      wr_addr = (($urandom % 2) == 0) ? 6'h2C : 6'h0C;
      tick(1);
    end
    wr_en = 1'b0; act = 6'd0; pix_valid = 1'b0;
    tag = "R9";
    sweep();

    finish_up();
  end
endmodule